// File: doc/BRIEF.md
# Multi-Granular Coherence Directory Set Controller

This block keeps the coherence directory for a group of cache sets. Each entry can track one cache line or one aligned block of sixteen consecutive lines (a region). A grain bit in each entry tells the two kinds apart. Both kinds of entry share the same set index, so a line and the region that contains it always land in the same set. One lookup therefore finds both.

A request carries an operation (read, write, writeback or directory eviction), a line address and the ID of the requesting node. A line with no entry of either kind always starts out tracked by a region entry. A line gets its own entry only when its sharing differs from the rest of its region. The controller answers every request with one response. The response reports which kind of entry served it, a per-node invalidation mask for the requested line, an optional forward to the current owner, and the details of any entry that was evicted.

Requests are handled one at a time by a three-state machine:
- IDLE: ready for a request.
- LOOK: search, decide, update the entries.
- RESP: present the response for one cycle.

The transitions are:
- IDLE to LOOK when a request is accepted.
- LOOK to RESP unconditionally.
- RESP to IDLE unconditionally.

Top module: `mgdir_set_ctrl`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1 and `resp_valid` is 0. The first lookup of any line reports `resp_src` = 0 (miss); the other codes are 1 for a region entry and 2 for a line entry.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the next two cycles. `resp_valid` is 1 for exactly the second cycle after acceptance.
- R3: A read or write that finds no entry allocates a region entry covering the aligned 16 lines that share line-address bits [19:4]. Set index bits [5:4] select the set, and bits [3:0] are the line within the region. A read miss leaves the region shared by the reader. A write miss leaves it modified and owned by the writer.
- R4: When a line entry and its region entry both match, the line entry serves the request and `resp_src` is 2.
- R5: A read that hits a shared region adds the reader to the region's sharer vector.
- R6: A write to a region whose only sharer is the writer makes the region modified. No line entry is created and no invalidation is sent.
- R7: A write to a region that has other sharers allocates a modified line entry owned by the writer. `resp_line_inv` holds the other sharers of the region. The region's own sharer vector is not changed.
- R8: A read by a non-owner of a modified region allocates a shared line entry holding the owner and the reader. It sets `resp_fwd_valid`, with `resp_fwd_node` set to the owner.
- R9: A writeback to a line covered only by a region entry changes nothing. A writeback hitting a line entry removes the requester from it, and frees the entry once no sharer is left.
- R10: An eviction request removes the line entry of the addressed line if there is one, and otherwise its region entry. The response reports `resp_vic_valid` = 1, `resp_vic_region` = grain, `resp_vic_inv` = the entry's sharers, and `resp_vic_line` = the entry's line address (region offset 0 for a region).
- R11: A write hitting a line entry invalidates all of its other sharers. A read by a non-owner of a modified line entry is forwarded to the owner, and the reader is added as a sharer.
- R12: An allocation uses the lowest-numbered invalid way of the set. Only when the set is full does it evict the least recently used way, which it reports on the victim outputs.
- R13: A line-entry allocation never picks the entry of its own region as the victim, even when that entry is the least recently used.
- R14: When a request is served by a line entry while its region entry also matches, the region entry's recency is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be accepted |
| req_op | input | 2 | 0 read, 1 write, 2 writeback, 3 directory eviction |
| req_line | input | 20 | Line address |
| req_node | input | 4 | Requesting node ID |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_src | output | 2 | 0 miss, 1 region entry, 2 line entry |
| resp_line_inv | output | 16 | Nodes to invalidate for the requested line |
| resp_fwd_valid | output | 1 | Request must be forwarded to an owner |
| resp_fwd_node | output | 4 | Owner to forward to |
| resp_vic_valid | output | 1 | An entry was evicted |
| resp_vic_region | output | 1 | Evicted entry was a region entry |
| resp_vic_line | output | 20 | Line address of the evicted entry |
| resp_vic_inv | output | 16 | Nodes to invalidate for the evicted entry |

## Verification
Two functions can fall into the same response: the exception-line invalidation of a region's other sharers, and the capacity eviction of another entry to make room for the new line entry. The bench provokes this by filling one set with eight region entries. It then rearranges recency so that the target region is the oldest and writes to one of its lines from a second sharer. The response must carry both the line invalidation mask and a victim. The victim must be the next-oldest region, not the target region. A follow-up double-hit access and a fresh miss then show whether the region's recency was left alone.

// File: rtl/dirg_pkg.sv
package dirg_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WBACK = 2'd2,
        OP_EVICT = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        CS_INV = 2'd0,
        CS_SHR = 2'd1,
        CS_MOD = 2'd2
    } coh_state_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_LOOK = 2'd1,
        FSM_RESP = 2'd2
    } fsm_e;

    typedef enum logic [1:0] {
        SRC_MISS   = 2'd0,
        SRC_REGION = 2'd1,
        SRC_LINE   = 2'd2
    } hit_src_e;

endpackage

// File: rtl/mgdir_match.sv
module mgdir_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 18,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0]             grain,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            line_tag,
    input  logic [TAG_W-1:0]            region_tag,
    output logic                        line_hit,
    output logic [WAY_W-1:0]            line_way,
    output logic                        region_hit,
    output logic [WAY_W-1:0]            region_way
);

    logic [WAYS-1:0] lh_vec;
    logic [WAYS-1:0] rh_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lh_vec[w] = vld[w] & ~grain[w] & (tags[w] == line_tag);
        assign rh_vec[w] = vld[w] &  grain[w] & (tags[w] == region_tag);
    end

    always_comb begin
        line_way   = '0;
        region_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lh_vec[w]) line_way   = WAY_W'(w);
            if (rh_vec[w]) region_way = WAY_W'(w);
        end
    end

    assign line_hit   = |lh_vec;
    assign region_hit = |rh_vec;

endmodule

// File: rtl/mgdir_lru.sv
module mgdir_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 8,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        touch_en,
    input  logic [SET_W-1:0]            touch_set,
    input  logic [WAY_W-1:0]            touch_way,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][WAY_W-1:0]  ages
);

    // Per set, the ages form a permutation of 0..WAYS-1; 0 is most recent.
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    assign ages = age_q[rd_set];

endmodule

// File: rtl/mgdir_victim.sv
module mgdir_victim #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages,
    input  logic                        excl_en,
    input  logic [WAY_W-1:0]            excl_way,
    output logic [WAY_W-1:0]            vic_way,
    output logic                        need_evict
);

    logic             have_free;
    logic             have_pick;
    logic [WAY_W-1:0] best_age;

    always_comb begin
        have_free = 1'b0;
        have_pick = 1'b0;
        best_age  = '0;
        vic_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                have_free = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
        if (!have_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!(excl_en && excl_way == WAY_W'(w)) &&
                    (!have_pick || ages[w] > best_age)) begin
                    have_pick = 1'b1;
                    best_age  = ages[w];
                    vic_way   = WAY_W'(w);
                end
            end
        end
    end

    assign need_evict = ~have_free;

endmodule

// File: rtl/mgdir_set_ctrl.sv
module mgdir_set_ctrl
    import dirg_pkg::*;
#(
    parameter int LINE_AW      = 20,
    parameter int NODES        = 16,
    parameter int WAYS         = 8,
    parameter int SETS         = 4,
    parameter int REGION_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_op,
    input  logic [LINE_AW-1:0]         req_line,
    input  logic [$clog2(NODES)-1:0]   req_node,
    output logic                       resp_valid,
    output logic [1:0]                 resp_src,
    output logic [NODES-1:0]           resp_line_inv,
    output logic                       resp_fwd_valid,
    output logic [$clog2(NODES)-1:0]   resp_fwd_node,
    output logic                       resp_vic_valid,
    output logic                       resp_vic_region,
    output logic [LINE_AW-1:0]         resp_vic_line,
    output logic [NODES-1:0]           resp_vic_inv
);

    localparam int NODE_W = $clog2(NODES);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int SET_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(REGION_LINES);
    localparam int TAG_W  = LINE_AW - SET_W;
    localparam int HI_W   = LINE_AW - SET_W - OFF_W;

    // ---------------- state machine ----------------
    fsm_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FSM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE: if (req_valid) state_d = FSM_LOOK;
            FSM_LOOK: state_d = FSM_RESP;
            FSM_RESP: state_d = FSM_IDLE;
            default:  state_d = FSM_IDLE;
        endcase
    end

    assign req_ready = (state_q == FSM_IDLE);

    // ---------------- captured request ----------------
    dir_op_e             op_q;
    logic [LINE_AW-1:0]  line_q;
    logic [NODE_W-1:0]   node_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_READ;
            line_q <= '0;
            node_q <= '0;
        end else if (req_valid && req_ready) begin
            op_q   <= dir_op_e'(req_op);
            line_q <= req_line;
            node_q <= req_node;
        end
    end

    logic [SET_W-1:0] set_q;
    logic [HI_W-1:0]  hi_q;
    logic [TAG_W-1:0] line_tag, region_tag;
    logic [NODES-1:0] req_bit;

    assign set_q      = line_q[OFF_W+SET_W-1:OFF_W];
    assign hi_q       = line_q[LINE_AW-1:OFF_W+SET_W];
    assign line_tag   = {hi_q, line_q[OFF_W-1:0]};
    assign region_tag = {hi_q, {OFF_W{1'b0}}};
    assign req_bit    = NODES'(1) << node_q;

    // ---------------- entry storage ----------------
    logic [SETS-1:0][WAYS-1:0]             e_vld, e_grain;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  e_tag;
    logic [SETS-1:0][WAYS-1:0][1:0]        e_st;
    logic [SETS-1:0][WAYS-1:0][NODES-1:0]  e_shr;

    logic [WAYS-1:0]             s_vld, s_grain;
    logic [WAYS-1:0][TAG_W-1:0]  s_tag;
    logic [WAYS-1:0][1:0]        s_st;
    logic [WAYS-1:0][NODES-1:0]  s_shr;

    assign s_vld   = e_vld[set_q];
    assign s_grain = e_grain[set_q];
    assign s_tag   = e_tag[set_q];
    assign s_st    = e_st[set_q];
    assign s_shr   = e_shr[set_q];

    // ---------------- lookup, recency, victim ----------------
    logic             l_hit, r_hit;
    logic [WAY_W-1:0] l_way, r_way;
    logic [WAYS-1:0][WAY_W-1:0] ages;
    logic [WAY_W-1:0] vic_way;
    logic             need_evict;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    mgdir_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .vld(s_vld), .grain(s_grain), .tags(s_tag),
        .line_tag(line_tag), .region_tag(region_tag),
        .line_hit(l_hit), .line_way(l_way),
        .region_hit(r_hit), .region_way(r_way)
    );

    mgdir_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_set(set_q), .touch_way(touch_way),
        .rd_set(set_q), .ages(ages)
    );

    // A matching region is never the victim of its own exception line.
    mgdir_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .vld(s_vld), .ages(ages),
        .excl_en(r_hit), .excl_way(r_way),
        .vic_way(vic_way), .need_evict(need_evict)
    );

    function automatic logic [NODE_W-1:0] owner_of(input logic [NODES-1:0] v);
        owner_of = '0;
        for (int i = NODES - 1; i >= 0; i--)
            if (v[i]) owner_of = NODE_W'(i);
    endfunction

    function automatic logic [LINE_AW-1:0] base_line(input logic [TAG_W-1:0] t,
                                                     input logic [SET_W-1:0] s);
        return {t[TAG_W-1:OFF_W], s, t[OFF_W-1:0]};
    endfunction

    // ---------------- decision ----------------
    logic              wr_en, wr_vld, wr_grain, alloc;
    logic [WAY_W-1:0]  wr_way;
    logic [TAG_W-1:0]  wr_tag;
    logic [1:0]        wr_st;
    logic [NODES-1:0]  wr_shr;
    hit_src_e          d_src;
    logic [NODES-1:0]  d_inv, d_vic_inv;
    logic              d_fwd, d_vic, d_vic_reg;
    logic [NODE_W-1:0] d_fwd_node;
    logic [LINE_AW-1:0] d_vic_line;

    always_comb begin
        wr_en = 1'b0; wr_way = vic_way; wr_vld = 1'b1; wr_grain = 1'b0;
        wr_tag = line_tag; wr_st = CS_SHR; wr_shr = req_bit;
        touch_en = 1'b0; touch_way = vic_way; alloc = 1'b0;
        d_src = SRC_MISS; d_inv = '0; d_fwd = 1'b0; d_fwd_node = '0;
        d_vic = 1'b0; d_vic_reg = 1'b0; d_vic_line = '0; d_vic_inv = '0;
        if (state_q == FSM_LOOK) begin
            if (l_hit) begin
                d_src = SRC_LINE;
                wr_way = l_way; wr_tag = s_tag[l_way];
                wr_st = s_st[l_way]; wr_shr = s_shr[l_way]; touch_way = l_way;
                unique case (op_q)
                    OP_READ: begin
                        touch_en = 1'b1;
                        if (s_st[l_way] == CS_MOD && s_shr[l_way] != req_bit) begin
                            d_fwd = 1'b1; d_fwd_node = owner_of(s_shr[l_way]);
                            wr_en = 1'b1; wr_st = CS_SHR; wr_shr = s_shr[l_way] | req_bit;
                        end else if (s_st[l_way] != CS_MOD) begin
                            wr_en = 1'b1; wr_shr = s_shr[l_way] | req_bit;
                        end
                    end
                    OP_WRITE: begin
                        touch_en = 1'b1; wr_en = 1'b1;
                        d_inv = s_shr[l_way] & ~req_bit;
                        wr_st = CS_MOD; wr_shr = req_bit;
                    end
                    OP_WBACK: begin
                        touch_en = 1'b1; wr_en = 1'b1;
                        wr_shr = s_shr[l_way] & ~req_bit;
                        wr_vld = |(s_shr[l_way] & ~req_bit);
                    end
                    OP_EVICT: begin
                        wr_en = 1'b1; wr_vld = 1'b0;
                        d_vic = 1'b1; d_vic_reg = 1'b0;
                        d_vic_line = base_line(s_tag[l_way], set_q);
                        d_vic_inv = s_shr[l_way];
                    end
                    default: ;
                endcase
            end else if (r_hit) begin
                d_src = SRC_REGION;
                wr_way = r_way; wr_grain = 1'b1; wr_tag = s_tag[r_way];
                wr_st = s_st[r_way]; wr_shr = s_shr[r_way]; touch_way = r_way;
                unique case (op_q)
                    OP_READ: begin
                        touch_en = 1'b1;
                        if (s_st[r_way] == CS_MOD && s_shr[r_way] != req_bit) begin
                            alloc = 1'b1; wr_en = 1'b1; wr_way = vic_way; touch_way = vic_way;
                            wr_grain = 1'b0; wr_tag = line_tag; wr_st = CS_SHR;
                            wr_shr = s_shr[r_way] | req_bit;
                            d_fwd = 1'b1; d_fwd_node = owner_of(s_shr[r_way]);
                        end else if (s_st[r_way] != CS_MOD) begin
                            wr_en = 1'b1; wr_shr = s_shr[r_way] | req_bit;
                        end
                    end
                    OP_WRITE: begin
                        touch_en = 1'b1; wr_en = 1'b1;
                        if (s_shr[r_way] == req_bit) begin
                            wr_st = CS_MOD;
                        end else begin
                            alloc = 1'b1; wr_way = vic_way; touch_way = vic_way;
                            wr_grain = 1'b0; wr_tag = line_tag; wr_st = CS_MOD;
                            wr_shr = req_bit; d_inv = s_shr[r_way] & ~req_bit;
                        end
                    end
                    OP_WBACK: ;
                    OP_EVICT: begin
                        wr_en = 1'b1; wr_vld = 1'b0;
                        d_vic = 1'b1; d_vic_reg = 1'b1;
                        d_vic_line = base_line(s_tag[r_way], set_q);
                        d_vic_inv = s_shr[r_way];
                    end
                    default: ;
                endcase
            end else if (op_q == OP_READ || op_q == OP_WRITE) begin
                alloc = 1'b1; wr_en = 1'b1; touch_en = 1'b1;
                wr_grain = 1'b1; wr_tag = region_tag; wr_shr = req_bit;
                wr_st = (op_q == OP_WRITE) ? CS_MOD : CS_SHR;
            end
            if (alloc && need_evict) begin
                d_vic = 1'b1; d_vic_reg = s_grain[vic_way];
                d_vic_line = base_line(s_tag[vic_way], set_q);
                d_vic_inv = s_shr[vic_way];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= '0; e_grain <= '0; e_tag <= '0; e_st <= '0; e_shr <= '0;
        end else if (wr_en) begin
            e_vld[set_q][wr_way]   <= wr_vld;
            e_grain[set_q][wr_way] <= wr_grain;
            e_tag[set_q][wr_way]   <= wr_tag;
            e_st[set_q][wr_way]    <= wr_vld ? wr_st : CS_INV;
            e_shr[set_q][wr_way]   <= wr_shr;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0; resp_src <= SRC_MISS; resp_line_inv <= '0;
            resp_fwd_valid <= 1'b0; resp_fwd_node <= '0;
            resp_vic_valid <= 1'b0; resp_vic_region <= 1'b0;
            resp_vic_line <= '0; resp_vic_inv <= '0;
        end else if (state_q == FSM_LOOK) begin
            resp_valid <= 1'b1; resp_src <= d_src; resp_line_inv <= d_inv;
            resp_fwd_valid <= d_fwd; resp_fwd_node <= d_fwd_node;
            resp_vic_valid <= d_vic; resp_vic_region <= d_vic_reg;
            resp_vic_line <= d_vic_line; resp_vic_inv <= d_vic_inv;
        end else begin
            resp_valid <= 1'b0; resp_line_inv <= '0;
            resp_fwd_valid <= 1'b0; resp_vic_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mgdir_chk.sv
module mgdir_chk #(
    parameter int NODES = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [1:0]                 req_op,
    input logic [$clog2(NODES)-1:0]   req_node,
    input logic                       resp_valid,
    input logic [NODES-1:0]           resp_line_inv,
    input logic                       resp_fwd_valid,
    input logic [$clog2(NODES)-1:0]   resp_fwd_node,
    input logic                       resp_vic_valid,
    input logic [NODES-1:0]           resp_vic_inv
);

    logic [$clog2(NODES)-1:0] cap_node;
    logic [1:0]               cap_op;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_node <= '0;
            cap_op   <= '0;
        end else if (req_valid && req_ready) begin
            cap_node <= req_node;
            cap_op   <= req_op;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!resp_valid && req_ready));

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);

    a_r7_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_line_inv[cap_node] == 1'b0));

    a_r8_fwd_to_other: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fwd_valid |-> (resp_valid && resp_fwd_node != cap_node && cap_op == 2'd0));

    a_r10_victim_has_sharers: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vic_valid |-> (resp_valid && resp_vic_inv != '0));

endmodule

bind mgdir_set_ctrl mgdir_chk #(.NODES(NODES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_node(req_node), .resp_valid(resp_valid),
    .resp_line_inv(resp_line_inv), .resp_fwd_valid(resp_fwd_valid),
    .resp_fwd_node(resp_fwd_node), .resp_vic_valid(resp_vic_valid),
    .resp_vic_inv(resp_vic_inv)
);

// File: tb/sim_mgdir_set_ctrl.sv
module sim_mgdir_set_ctrl;

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, WB = 2'd2, EV = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_line = '0;
    logic [3:0]  req_node = '0;
    logic        resp_valid;
    logic [1:0]  resp_src;
    logic [15:0] resp_line_inv;
    logic        resp_fwd_valid;
    logic [3:0]  resp_fwd_node;
    logic        resp_vic_valid;
    logic        resp_vic_region;
    logic [19:0] resp_vic_line;
    logic [15:0] resp_vic_inv;

    int checks = 0;
    int errors = 0;

    logic [1:0]  g_src;
    logic [15:0] g_inv, g_vinv;
    logic        g_fwd, g_vic, g_vreg;
    logic [3:0]  g_fwdn;
    logic [19:0] g_vline;

    always #5 clk = ~clk;

    mgdir_set_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_line(req_line), .req_node(req_node),
        .resp_valid(resp_valid), .resp_src(resp_src), .resp_line_inv(resp_line_inv),
        .resp_fwd_valid(resp_fwd_valid), .resp_fwd_node(resp_fwd_node),
        .resp_vic_valid(resp_vic_valid), .resp_vic_region(resp_vic_region),
        .resp_vic_line(resp_vic_line), .resp_vic_inv(resp_vic_inv)
    );

    function automatic logic [19:0] mk(input int hi, input int st, input int off);
        return {hi[13:0], st[1:0], off[3:0]};
    endfunction

    function automatic logic [15:0] nb(input int n);
        return 16'(1) << n;
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] op, input logic [19:0] line, input int node);
        int n;
        @(negedge clk);
        chk("R2", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_op = op; req_line = line; req_node = node[3:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "busy, no response yet", {30'd0, resp_valid, req_ready}, 0);
        n = 0;
        @(negedge clk);
        while (!resp_valid && n < 8) begin
            @(negedge clk);
            n++;
        end
        chk("R2", "response latency", 32'(n), 0);
        g_src = resp_src; g_inv = resp_line_inv; g_fwd = resp_fwd_valid;
        g_fwdn = resp_fwd_node; g_vic = resp_vic_valid; g_vreg = resp_vic_region;
        g_vline = resp_vic_line; g_vinv = resp_vic_inv;
    endtask

    task automatic t_reset();
        chk("R1", "ready after reset", 32'(req_ready), 1);
        chk("R1", "no response after reset", 32'(resp_valid), 0);
        do_req(RD, mk(1, 0, 3), 2);
        chk("R1", "first lookup misses", 32'(g_src), 0);
        chk("R1", "no inv on miss", 32'(g_inv), 0);
        chk("R12", "free way, no victim", 32'(g_vic), 0);
    endtask

    task automatic t_cover();
        do_req(RD, mk(1, 0, 9), 2);
        chk("R3", "other line of region hits region", 32'(g_src), 1);
        do_req(RD, mk(2, 0, 3), 2);
        chk("R3", "other tag misses", 32'(g_src), 0);
        do_req(RD, mk(1, 1, 3), 2);
        chk("R3", "other set misses", 32'(g_src), 0);
        do_req(WR, mk(8, 1, 0), 3);
        chk("R3", "write miss", 32'(g_src), 0);
        do_req(RD, mk(8, 1, 7), 4);
        chk("R3", "write miss made region modified (fwd)", {31'd0, g_fwd}, 1);
        chk("R3", "owner is writer", 32'(g_fwdn), 3);
    endtask

    task automatic t_sharer_evict();
        do_req(RD, mk(3, 0, 0), 4);
        do_req(RD, mk(3, 0, 7), 9);
        chk("R5", "read hits region", 32'(g_src), 1);
        do_req(EV, mk(3, 0, 12), 0);
        chk("R10", "evict valid", 32'(g_vic), 1);
        chk("R10", "evict region grain", 32'(g_vreg), 1);
        chk("R5", "region sharers include reader", 32'(g_vinv), 32'(nb(4) | nb(9)));
        chk("R10", "evicted region base", 32'(g_vline), 32'(mk(3, 0, 0)));
        do_req(RD, mk(3, 0, 1), 4);
        chk("R10", "after evict lookup misses", 32'(g_src), 0);
        chk("R12", "reuses freed way, no victim", 32'(g_vic), 0);
    endtask

    task automatic t_private_write();
        do_req(RD, mk(4, 1, 0), 5);
        do_req(WR, mk(4, 1, 2), 5);
        chk("R6", "sole writer served by region", 32'(g_src), 1);
        chk("R6", "sole writer no inv", 32'(g_inv), 0);
        do_req(RD, mk(4, 1, 6), 6);
        chk("R8", "non-owner read forwarded", {31'd0, g_fwd}, 1);
        chk("R8", "forward to owner", 32'(g_fwdn), 5);
        do_req(RD, mk(4, 1, 2), 5);
        chk("R6", "no line entry from private write", 32'(g_src), 1);
        chk("R6", "owner read not forwarded", {31'd0, g_fwd}, 0);
        do_req(WR, mk(4, 1, 6), 6);
        chk("R8", "line entry allocated", 32'(g_src), 2);
        chk("R11", "line write invalidates owner", 32'(g_inv), 32'(nb(5)));
    endtask

    task automatic t_exception();
        do_req(RD, mk(5, 2, 0), 1);
        do_req(RD, mk(5, 2, 0), 3);
        do_req(WR, mk(5, 2, 4), 3);
        chk("R7", "write served by region", 32'(g_src), 1);
        chk("R7", "other sharers invalidated", 32'(g_inv), 32'(nb(1)));
        chk("R7", "no victim", 32'(g_vic), 0);
        do_req(RD, mk(5, 2, 4), 3);
        chk("R4", "line entry wins", 32'(g_src), 2);
        chk("R11", "owner read no fwd", {31'd0, g_fwd}, 0);
        do_req(EV, mk(5, 2, 9), 0);
        chk("R10", "region evicted", 32'(g_vreg), 1);
        chk("R7", "region sharers unchanged", 32'(g_vinv), 32'(nb(1) | nb(3)));
        chk("R10", "region base", 32'(g_vline), 32'(mk(5, 2, 0)));
        do_req(RD, mk(5, 2, 4), 8);
        chk("R10", "line survives region evict", 32'(g_src), 2);
        chk("R11", "read of modified line forwarded", {28'd0, g_fwd, g_fwdn[2:0]}, 32'h0b);
        do_req(EV, mk(5, 2, 4), 0);
        chk("R10", "line evicted first", 32'(g_vreg), 0);
        chk("R11", "reader added to line", 32'(g_vinv), 32'(nb(3) | nb(8)));
        chk("R10", "line address", 32'(g_vline), 32'(mk(5, 2, 4)));
        do_req(RD, mk(5, 2, 4), 8);
        chk("R10", "both gone, miss", 32'(g_src), 0);
    endtask

    task automatic t_writeback();
        do_req(RD, mk(6, 2, 0), 1);
        do_req(RD, mk(6, 2, 1), 2);
        do_req(WB, mk(6, 2, 1), 2);
        chk("R9", "region writeback served by region", 32'(g_src), 1);
        chk("R9", "region writeback no outputs", {15'd0, g_fwd, g_inv}, 0);
        do_req(EV, mk(6, 2, 0), 0);
        chk("R9", "writer kept in region", 32'(g_vinv), 32'(nb(1) | nb(2)));
        do_req(RD, mk(7, 2, 0), 4);
        do_req(RD, mk(7, 2, 0), 5);
        do_req(WR, mk(7, 2, 5), 5);
        chk("R7", "exception inv", 32'(g_inv), 32'(nb(4)));
        do_req(WB, mk(7, 2, 5), 5);
        chk("R9", "writeback on line entry", 32'(g_src), 2);
        do_req(RD, mk(7, 2, 5), 6);
        chk("R9", "empty line entry freed", 32'(g_src), 1);
    endtask

    task automatic t_lru();
        for (int h = 10; h < 18; h++) begin
            do_req(RD, mk(h, 3, 0), 1);
            chk("R12", "fill without victim", 32'(g_vic), 0);
        end
        do_req(RD, mk(18, 3, 0), 1);
        chk("R12", "full set evicts", 32'(g_vic), 1);
        chk("R12", "oldest region evicted", 32'(g_vline), 32'(mk(10, 3, 0)));
        chk("R12", "victim sharers", 32'(g_vinv), 32'(nb(1)));
        do_req(RD, mk(11, 3, 0), 2);
        for (int h = 12; h < 19; h++) begin
            do_req(RD, mk(h, 3, 0), 1);
        end
        do_req(WR, mk(11, 3, 5), 2);
        chk("R7", "same response: line inv", 32'(g_inv), 32'(nb(1)));
        chk("R13", "same response: victim present", 32'(g_vic), 1);
        chk("R13", "own region spared", 32'(g_vline), 32'(mk(12, 3, 0)));
        chk("R13", "victim is region", 32'(g_vreg), 1);
        do_req(RD, mk(11, 3, 5), 2);
        chk("R4", "double hit uses line", 32'(g_src), 2);
        do_req(RD, mk(19, 3, 0), 1);
        chk("R14", "region recency untouched", 32'(g_vline), 32'(mk(11, 3, 0)));
        chk("R14", "region sharers", 32'(g_vinv), 32'(nb(1) | nb(2)));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cover();
        t_sharer_evict();
        t_private_write();
        t_exception();
        t_writeback();
        t_lru();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule